// File: doc/BRIEF.md
# Priority Packet Insertion Transmit Path

This block is the host-side transmit merger of a serial camera link. It takes command and test traffic as 32-bit words with a per-byte K mask and turns it into one 8-bit character stream with a K flag per character for the physical layer. Three further traffic classes are merged into that stream by priority. Idle words fill any word slot that has no command data. Trigger-acknowledge packets are inserted at word boundaries. Trigger packets preempt the stream at any character.

The path has two sections. The word section holds an idle filler followed by an acknowledge inserter. Because the acknowledge inserter is the later stage, no idle word can ever land inside an acknowledge packet. A word-to-character converter follows. After it, the trigger inserter stalls the converter for the length of a trigger packet, and the interrupted word then resumes at the byte where it stopped.

Top module: `lnk_tx_merge`

## Requirements
- R1: A trigger packet is TRIG_REP K characters, followed by TRIG_REP data characters that each equal the requested delay. The K character is 0x5C when the mode bit is 0 and 0x7C when it is 1. No other character appears between the first and last character of a trigger packet.
- R2: When no trigger is in progress or pending and the output is ready, the first trigger character is presented after the second rising edge that follows the strobe cycle.
- R3: A trigger may begin at any byte offset within a word, and the interrupted word continues afterwards from the byte where it stopped.
- R4: A trigger strobe received while a trigger packet is in flight is sent as a second packet directly after the first, with no character in between.
- R5: The bytes of each word leave least-significant byte first, and byte b carries K flag bit b of the word's K mask.
- R6: Every accepted command word reaches the output complete, byte-exact and in acceptance order.
- R7: A word slot with no valid command word carries the idle word. Its bytes are 0xBC (K), 0x3C, 0x3C, 0xB5 in output order.
- R8: A trigger-acknowledge packet is two words that start on a word boundary: four K characters 0xDC, then four data characters 0x01. No idle or command word is placed between its two words.
- R9: Several acknowledge strobes received before a pending acknowledge has started produce exactly one acknowledge packet.
- R10: A pending acknowledge is sent before the next command word, even when command data is waiting.
- R11: While reset is asserted the output is not valid. After reset with no command data, the stream begins with idle words.
- R12: While the output is valid and not ready, the character and K flag hold steady and valid stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command/test word valid |
| cmd_ready | output | 1 | Command/test word accepted |
| cmd_data | input | 32 | Command/test word, byte 0 in bits 7:0 |
| cmd_kmask | input | 4 | K flag per byte of cmd_data |
| trig_stb | input | 1 | Single-cycle trigger request |
| trig_delay | input | 8 | Delay value carried by the trigger packet |
| trig_mode | input | 1 | Link-trigger mode, selects the trigger K code |
| ack_stb | input | 1 | Single-cycle trigger-acknowledge request |
| phy_valid | output | 1 | Output character valid |
| phy_ready | input | 1 | PHY accepts a character |
| phy_char | output | 8 | Output character |
| phy_k | output | 1 | Output character is a K code |

## Verification
The bench uses the default TRIG_REP of 3, which gives a six-character trigger packet that fits easily between command words. This makes it practical to sweep every delay value from 0 to 255 with both modes. Across that sweep, triggers land at all four byte offsets under varying source gaps and output back-pressure. Each command word's bytes and K mask come from its sequence number, so every byte and every K bit of the stream can be predicted arithmetically. Directed cases cover start latency, back-to-back triggers, merged acknowledges, acknowledge priority over waiting data, and stall stability.

// File: rtl/lnk_tx_pkg.sv
// Shared constants and types for the transmit merger.
// Assumes 8-bit characters and a four-character word.
package lnk_tx_pkg;
    localparam int CHAR_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = CHAR_W * WORD_BYTES;
    localparam int ACK_WORDS  = 2;

    localparam logic [CHAR_W-1:0] K_TRIG_EDGE = 8'h5C;
    localparam logic [CHAR_W-1:0] K_TRIG_LVL  = 8'h7C;
    localparam logic [CHAR_W-1:0] K_ACK       = 8'hDC;
    localparam logic [CHAR_W-1:0] K_IDLE      = 8'hBC;
    localparam logic [CHAR_W-1:0] D_IDLE_A    = 8'h3C;
    localparam logic [CHAR_W-1:0] D_IDLE_B    = 8'hB5;
    localparam logic [CHAR_W-1:0] D_ACK       = 8'h01;

    typedef struct packed {
        logic [WORD_BYTES-1:0] k;
        logic [WORD_W-1:0]     data;
    } word_t;

    // Idle word: one K char in byte 0, fixed data in bytes 1..3.
    function automatic word_t idle_word();
        word_t w;
        w.k    = 4'b0001;
        w.data = {D_IDLE_B, D_IDLE_A, D_IDLE_A, K_IDLE};
        return w;
    endfunction

    // Acknowledge packet word by index: all-K header then data payload.
    function automatic word_t ack_word(input int idx);
        word_t w;
        if (idx == 0) begin
            w.k    = '1;
            w.data = {WORD_BYTES{K_ACK}};
        end else begin
            w.k    = '0;
            w.data = {WORD_BYTES{D_ACK}};
        end
        return w;
    endfunction
endpackage

// File: rtl/lnk_tx_idle_fill.sv
// Idle filler: passes a command word when one is valid, otherwise offers
// the fixed idle word. Purely combinational; its output is always valid.
module lnk_tx_idle_fill
    import lnk_tx_pkg::*;
(
    input  logic  cmd_valid,
    output logic  cmd_ready,
    input  word_t cmd_word,
    output logic  out_valid,
    output word_t out_word,
    input  logic  out_ready
);
    // Word select: command data wins, the idle word fills the gap.
    assign out_word  = cmd_valid ? cmd_word : idle_word();
    assign out_valid = 1'b1;
    assign cmd_ready = out_ready;
endmodule

// File: rtl/lnk_tx_ack_ins.sv
// Acknowledge inserter: holds a request until the next word boundary
// (a downstream word acceptance), then sends ACK_WORDS words back to back
// while the upstream is stalled. Requests made before start are merged.
module lnk_tx_ack_ins
    import lnk_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ack_stb,
    input  logic  up_valid,
    output logic  up_ready,
    input  word_t up_word,
    output logic  dn_valid,
    output word_t dn_word,
    input  logic  dn_ready
);
    localparam int AW = (ACK_WORDS > 1) ? $clog2(ACK_WORDS) : 1;

    logic          ack_pend;
    logic          ack_busy;
    logic [AW-1:0] ack_idx;
    logic          active;
    logic          take;

    assign active   = ack_pend | ack_busy;
    assign take     = dn_ready & dn_valid;
    assign dn_valid = active | up_valid;
    assign dn_word  = active ? ack_word(int'(ack_idx)) : up_word;
    assign up_ready = dn_ready & ~active;

    // Packet sequencing: advance the word index on every accepted ack word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_busy <= 1'b0;
            ack_idx  <= '0;
        end else if (take && active) begin
            if (ack_idx == AW'(ACK_WORDS - 1)) begin
                ack_busy <= 1'b0;
                ack_idx  <= '0;
            end else begin
                ack_busy <= 1'b1;
                ack_idx  <= ack_idx + 1'b1;
            end
        end
    end

    // Request flag: set by a strobe, cleared when its packet begins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_pend <= 1'b0;
        else if (ack_stb)
            ack_pend <= 1'b1;
        else if (take && ack_pend && !ack_busy)
            ack_pend <= 1'b0;
    end

    // R8
    ack_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && active && ack_idx != AW'(ACK_WORDS - 1))
        |=> (ack_busy && ack_idx == $past(ack_idx) + 1'b1));

    // R9
    ack_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pend && !(take && !ack_busy)) |=> ack_pend);
endmodule

// File: rtl/lnk_tx_w2c.sv
// Word-to-character converter: loads one word at a time and emits its
// bytes least-significant first with the matching K bit. It holds its
// position whenever the character side is not ready.
module lnk_tx_w2c
    import lnk_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w_valid,
    output logic              w_ready,
    input  word_t             w_word,
    output logic              c_valid,
    output logic [CHAR_W-1:0] c_char,
    output logic              c_k,
    input  logic              c_ready
);
    localparam int IDX_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

    word_t              hold;
    logic               full;
    logic [IDX_W-1:0]   idx;
    logic [CHAR_W-1:0]  bytes [WORD_BYTES];
    logic               c_take;
    logic               last;
    logic               load;

    // Byte lanes of the held word.
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign bytes[g] = hold.data[g*CHAR_W +: CHAR_W];
    end

    assign c_valid = full;
    assign c_char  = bytes[idx];
    assign c_k     = hold.k[idx];
    assign c_take  = full & c_ready;
    assign last    = (idx == IDX_W'(WORD_BYTES - 1));
    assign load    = ~full | (c_take & last);
    assign w_ready = load;

    // Word register: reload at the word boundary, else step the byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
            full <= 1'b0;
            idx  <= '0;
        end else if (load) begin
            hold <= w_word;
            full <= w_valid;
            idx  <= '0;
        end else if (c_take) begin
            idx  <= idx + 1'b1;
        end
    end

    // R3
    resume_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !c_ready) |=> (full && $stable(idx) && $stable(hold)));

    // R5
    lsb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && w_valid) |=> (full && idx == '0));
endmodule

// File: rtl/lnk_tx_trig_ins.sv
// Trigger inserter: at any character boundary, sends a packet of TRIG_REP
// K codes followed by TRIG_REP copies of the delay, and stalls the
// converter meanwhile. A strobe during a packet is queued for the next one.
// Starts only when the current output character is not stalled.
module lnk_tx_trig_ins
    import lnk_tx_pkg::*;
#(
    parameter int TRIG_REP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_stb,
    input  logic [CHAR_W-1:0] trig_delay,
    input  logic              trig_mode,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [CHAR_W-1:0] up_char,
    input  logic              up_k,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_char,
    output logic              out_k,
    input  logic              out_ready
);
    localparam int TRIG_LEN = 2 * TRIG_REP;
    localparam int CW       = $clog2(TRIG_LEN);

    logic              pend;
    logic [CHAR_W-1:0] pend_delay;
    logic              pend_mode;
    logic              busy;
    logic [CW-1:0]     idx;
    logic [CHAR_W-1:0] cur_delay;
    logic              cur_mode;
    logic              take;
    logic              done;
    logic              start;
    logic              k_part;

    assign take   = busy & out_ready;
    assign done   = take & (idx == CW'(TRIG_LEN - 1));
    assign start  = pend & ((~busy & (out_ready | ~up_valid)) | done);
    assign k_part = (idx < CW'(TRIG_REP));

    // Output mux: trigger characters override the converter stream.
    always_comb begin
        if (busy) begin
            out_char = k_part ? (cur_mode ? K_TRIG_LVL : K_TRIG_EDGE) : cur_delay;
            out_k    = k_part;
        end else begin
            out_char = up_char;
            out_k    = up_k;
        end
    end
    assign out_valid = busy | up_valid;
    assign up_ready  = ~busy & out_ready;

    // Packet state: start from the pending request, step on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            idx       <= '0;
            cur_delay <= '0;
            cur_mode  <= 1'b0;
        end else if (start) begin
            busy      <= 1'b1;
            idx       <= '0;
            cur_delay <= pend_delay;
            cur_mode  <= pend_mode;
        end else if (done) begin
            busy      <= 1'b0;
            idx       <= '0;
        end else if (take) begin
            idx       <= idx + 1'b1;
        end
    end

    // Request latch: capture strobe fields, clear when the packet starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend       <= 1'b0;
            pend_delay <= '0;
            pend_mode  <= 1'b0;
        end else if (trig_stb) begin
            pend       <= 1'b1;
            pend_delay <= trig_delay;
            pend_mode  <= trig_mode;
        end else if (start) begin
            pend       <= 1'b0;
        end
    end

    // R1
    trig_unbroken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R2
    trig_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_stb && !busy && !pend) |=> pend);

    // R4
    trig_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pend) |=> (busy && idx == '0));
endmodule

// File: rtl/lnk_tx_merge.sv
// Transmit merger top: idle filler -> acknowledge inserter -> word to
// character converter -> trigger inserter -> PHY character port.
// Assumes single-cycle strobes for trigger and acknowledge requests.
module lnk_tx_merge
    import lnk_tx_pkg::*;
#(
    parameter int TRIG_REP = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [31:0] cmd_data,
    input  logic [3:0]  cmd_kmask,
    input  logic        trig_stb,
    input  logic [7:0]  trig_delay,
    input  logic        trig_mode,
    input  logic        ack_stb,
    output logic        phy_valid,
    input  logic        phy_ready,
    output logic [7:0]  phy_char,
    output logic        phy_k
);
    word_t             cmd_w;
    word_t             fill_w;
    word_t             ack_w;
    logic              fill_valid;
    logic              fill_ready;
    logic              ack_valid;
    logic              ack_ready;
    logic              cv_valid;
    logic              cv_ready;
    logic [CHAR_W-1:0] cv_char;
    logic              cv_k;

    assign cmd_w.k    = cmd_kmask;
    assign cmd_w.data = cmd_data;

    lnk_tx_idle_fill u_fill (
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_word  (cmd_w),
        .out_valid (fill_valid),
        .out_word  (fill_w),
        .out_ready (fill_ready)
    );

    lnk_tx_ack_ins u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_stb  (ack_stb),
        .up_valid (fill_valid),
        .up_ready (fill_ready),
        .up_word  (fill_w),
        .dn_valid (ack_valid),
        .dn_word  (ack_w),
        .dn_ready (ack_ready)
    );

    lnk_tx_w2c u_w2c (
        .clk     (clk),
        .rst_n   (rst_n),
        .w_valid (ack_valid),
        .w_ready (ack_ready),
        .w_word  (ack_w),
        .c_valid (cv_valid),
        .c_char  (cv_char),
        .c_k     (cv_k),
        .c_ready (cv_ready)
    );

    lnk_tx_trig_ins #(.TRIG_REP(TRIG_REP)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_stb   (trig_stb),
        .trig_delay (trig_delay),
        .trig_mode  (trig_mode),
        .up_valid   (cv_valid),
        .up_ready   (cv_ready),
        .up_char    (cv_char),
        .up_k       (cv_k),
        .out_valid  (phy_valid),
        .out_char   (phy_char),
        .out_k      (phy_k),
        .out_ready  (phy_ready)
    );

    // R12
    stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_valid && !phy_ready)
        |=> (phy_valid && $stable(phy_char) && $stable(phy_k)));
endmodule

// File: tb/lnk_tx_merge_bench.sv
module lnk_tx_merge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_data = '0;
    logic [3:0]  cmd_kmask = '0;
    logic        trig_stb = 1'b0;
    logic [7:0]  trig_delay = '0;
    logic        trig_mode = 1'b0;
    logic        ack_stb = 1'b0;
    logic        phy_valid;
    logic        phy_ready = 1'b1;
    logic [7:0]  phy_char;
    logic        phy_k;

    always #5 clk = ~clk;

    lnk_tx_merge u_lnk_tx_merge (.*);

    int n_tests = 0, n_fail = 0;
    int cyc = 0;
    int src_en = 0, gap_mode = 0, rdy_mode = 0;
    int src_idx = 0, rx_idx = 0;
    bit src_fire = 0;
    // trigger bookkeeping
    int trig_tx = 0, trig_rx = 0;
    logic [7:0] exp_delay [0:1023];
    logic       exp_mode  [0:1023];
    int tstart [0:1023];
    int tend   [0:1023];
    int off_hits [0:3];
    // stream parser state
    int trig_pos = -1;
    logic [7:0] trig_code = '0;
    bit trig_ok = 1;
    logic [31:0] acc = '0;
    logic [3:0]  acck = '0;
    int accn = 0, ack_state = 0, acks_rx = 0, acks_exp = 0;
    int wcount = 0, gchar = 0;
    byte cls [0:16383];

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [35:0] exp_word(input int i);
        logic [31:0] d;
        for (int b = 0; b < 4; b++) d[b*8 +: 8] = 8'h80 | 8'((i*4 + b) & 63);
        return {4'(i & 15), d};
    endfunction

    // classify a completed word
    task automatic word_done();
        logic [35:0] e;
        int c;
        if (ack_state == 1) begin
            chk(acck == 4'h0 && acc == 32'h01010101, "R8 ack second word", {acck, acc}, 36'h001010101);
            ack_state = 0; acks_rx++; c = 4;
        end else if (acck == 4'hF && acc == 32'hDCDCDCDC) begin
            ack_state = 1; c = 3;
        end else if (acck == 4'h1 && acc == 32'hB53C3CBC) begin
            c = 1;
        end else begin
            e = exp_word(rx_idx);
            chk({acck, acc} == e, "R5 R6 command word", {acck, acc}, e);
            rx_idx++; c = 2;
        end
        if (wcount < 16384) cls[wcount] = byte'(c);
        wcount++;
        acc = '0; acck = '0; accn = 0;
    endtask

    task automatic feed(input logic [7:0] c, input logic k);
        if (trig_pos >= 0) begin
            if (trig_pos < 3) trig_ok &= (k && c == trig_code);
            else              trig_ok &= (!k && c == exp_delay[trig_rx]);
            trig_pos++;
            if (trig_pos == 6) begin
                chk(trig_ok, "R1 trigger packet", trig_rx, trig_rx);
                tend[trig_rx] = gchar;
                trig_rx++; trig_pos = -1;
            end
        end else if (k && (c == 8'h5C || c == 8'h7C)) begin
            chk(c == (exp_mode[trig_rx] ? 8'h7C : 8'h5C), "R1 trigger code", c,
                exp_mode[trig_rx] ? 8'h7C : 8'h5C);
            trig_code = c; trig_ok = 1; trig_pos = 1;
            tstart[trig_rx] = gchar;
            off_hits[accn]++;
        end else begin
            acc[accn*8 +: 8] = c; acck[accn] = k; accn++;
            if (accn == 4) word_done();
        end
        gchar++;
    endtask

    // monitor and handshake sampling away from the clock edge
    always @(negedge clk) begin
        if (!rst_n) chk(phy_valid == 1'b0, "R11 valid low in reset", phy_valid, 0);
        else if (phy_valid && phy_ready) feed(phy_char, phy_k);
        src_fire = cmd_valid && cmd_ready;
    end

    // command source and PHY ready drivers
    always begin
        @(posedge clk); #2;
        cyc++;
        if (src_fire) src_idx++;
        src_fire = 0;
        cmd_valid = (src_en != 0) && (gap_mode == 0 || (cyc % 5) != 3);
        {cmd_kmask, cmd_data} = exp_word(src_idx);
        case (rdy_mode)
            0: phy_ready = 1'b1;
            1: phy_ready = (((cyc ^ (cyc >> 2)) & 3) != 0);
            default: phy_ready = 1'b0;
        endcase
    end

    task automatic trig(input logic [7:0] d, input logic m);
        @(posedge clk); #2;
        exp_delay[trig_tx] = d; exp_mode[trig_tx] = m; trig_tx++;
        trig_stb = 1; trig_delay = d; trig_mode = m;
        @(posedge clk); #2;
        trig_stb = 0;
    endtask

    task automatic ack();
        @(posedge clk); #2; ack_stb = 1;
        @(posedge clk); #2; ack_stb = 0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int mark, ab, wb;
        logic [7:0] sc; logic sk;
        for (int i = 0; i < 4; i++) off_hits[i] = 0;
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (20) @(posedge clk);
        // R11 / R7: idle words after reset
        chk(cls[0] == 1 && cls[1] == 1, "R11 R7 idle after reset", cls[0], 1);

        // R2: latency with idle stream and ready high
        @(posedge clk); #2;
        exp_delay[trig_tx] = 8'h5A; exp_mode[trig_tx] = 0; trig_tx++;
        trig_stb = 1; trig_delay = 8'h5A; trig_mode = 0;
        @(posedge clk); #2; trig_stb = 0;
        @(posedge clk); #3;
        chk(phy_k && phy_char == 8'h5C, "R2 trigger latency", {phy_k, phy_char}, 9'h15C);
        repeat (20) @(posedge clk);

        // R4: back-to-back triggers
        trig(8'h11, 1);
        repeat (2) @(posedge clk);
        trig(8'h22, 0);
        repeat (30) @(posedge clk);
        chk(tstart[trig_tx-1] == tend[trig_tx-2] + 1, "R4 queued trigger follows",
            tstart[trig_tx-1], tend[trig_tx-2] + 1);

        // R9 R10 R12: stall, merged ack, ack ahead of waiting data
        src_en = 1; gap_mode = 0; rdy_mode = 0;
        repeat (13) @(posedge clk);
        rdy_mode = 2;
        repeat (3) @(posedge clk);
        @(negedge clk); #1; sc = phy_char; sk = phy_k;
        ack(); repeat (2) @(posedge clk); ack();
        @(negedge clk); #1;
        chk(phy_valid && phy_char == sc && phy_k == sk, "R12 stall holds char", {phy_k, phy_char}, {sk, sc});
        mark = wcount; ab = acks_rx;
        rdy_mode = 0;
        repeat (40) @(posedge clk);
        acks_exp++;
        chk(cls[mark] == 2, "R10 held word finishes first", cls[mark], 2);
        chk(cls[mark+1] == 3 && cls[mark+2] == 4, "R8 ack at boundary", {cls[mark+1], cls[mark+2]}, 16'h0304);
        chk(cls[mark+3] == 2, "R10 data resumes after ack", cls[mark+3], 2);
        chk(acks_rx == ab + 1, "R9 merged ack count", acks_rx - ab, 1);

        // sweep: every delay, both modes, varied gaps and back-pressure
        for (int d = 0; d < 256; d++) begin
            gap_mode = (d >> 1) & 1;
            rdy_mode = (d < 128) ? 1 : 0;
            repeat (d % 7) @(posedge clk);
            trig(8'(d), d[0]);
            repeat (16) @(posedge clk);
            if ((d % 16) == 5) begin
                ack(); acks_exp++;
                repeat (24) @(posedge clk);
            end
        end

        // drain
        src_en = 0; rdy_mode = 0;
        repeat (200) @(posedge clk);
        wb = wcount;
        chk(rx_idx == src_idx, "R6 all command words delivered", rx_idx, src_idx);
        chk(trig_rx == trig_tx, "R1 all triggers delivered", trig_rx, trig_tx);
        chk(acks_rx == acks_exp, "R8 ack packet count", acks_rx, acks_exp);
        for (int o = 1; o < 4; o++)
            chk(off_hits[o] > 0, "R3 trigger at mid-word offset", off_hits[o], 1);
        chk(cls[wb-1] == 1 && ack_state == 0, "R7 idle when source empty", cls[wb-1], 1);
        finish_run();
    end
endmodule